// File: doc/BRIEF.md
# Synchronous Serial Port Register and Interrupt Unit

This block is the software-visible face of a synchronous serial port. A host reaches it through a 32-bit register bus with a valid/ready request and a response one cycle later. It holds two control words, a clock prescale byte and an interrupt enable mask. It turns the fill levels of an external 8-entry transmit queue and an 8-entry receive queue into a status word, a raw interrupt vector, a masked interrupt vector and a single level-sensitive interrupt line.

The queues and the shifting engine live elsewhere. This unit pushes into the transmit queue when the data register is written and pops the receive queue when the data register is read. It trims every transmitted word to the frame size chosen in control word 0. A read-only window of eight identification bytes sits at the top of the 4 KB address region.

Top module: `ssp_reg_unit`

## Requirements
- R1: After reset the status word reads 0x03, the raw interrupt vector reads 0x08, the mask reads 0, and the interrupt line is low.
- R2: Status bit 0 is set when the transmit level is 0. Bit 1 is set when the transmit level is below 8. Bit 2 is set when the receive level is nonzero. Bit 3 is set when the receive level is 8. The status word reflects a level change one clock after the change.
- R3: Status bit 4 (busy) is set exactly when the transmit queue holds at least one entry.
- R4: Raw interrupt bit 2 is set when the receive level is 4 or more. Raw interrupt bit 3 is set when the transmit level is 4 or less. Bits 1:0 read 0.
- R5: The interrupt line is high exactly when the raw vector AND the mask is nonzero, and offset 0x1C returns that AND.
- R6: A data register read (offset 0x08) with an empty receive queue returns 0 and raises no pop. Otherwise it pops once and returns the head word.
- R7: A data register write when the transmit level is 8 raises no push. At any lower level it pushes once.
- R8: The pushed word is the written value ANDed with a mask of (control0[3:0] + 1) ones.
- R9: The prescale register (offset 0x10) keeps only bits 7:0 of a write.
- R10: Reads of offsets 0xFE0 through 0xFFC return, one per word, the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Offset 0x20 reads 0 and ignores writes, without an error. Any other unlisted offset, and any address with bits 1:0 nonzero, reads 0, changes nothing, and returns an error flag that lasts one cycle.
- R12: Every accepted request gets exactly one response (rsp_valid) on the following cycle, and req_ready is always high.
- R13: Control 0 (offset 0x00, 16 bits), control 1 (offset 0x04, 4 bits) and the mask (offset 0x14, 4 bits) read back the bits last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the 4 KB region |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Unmapped or misaligned access |
| tx_push | output | 1 | Push strobe toward the transmit queue |
| tx_push_data | output | 16 | Frame-trimmed word to push |
| tx_level | input | LVL_W | Transmit queue fill level |
| rx_pop | output | 1 | Pop strobe toward the receive queue |
| rx_pop_data | input | 16 | Head word of the receive queue |
| rx_level | input | LVL_W | Receive queue fill level |
| ctrl0_o | output | 16 | Control word 0 to the engine |
| ctrl1_o | output | 4 | Control word 1 to the engine |
| presc_o | output | 8 | Clock prescale byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the level thresholds at 4 and 8 on both queues. A comparison off by one would flip the interrupt or full bit exactly at those levels. It reads status in the same cycle that a level changes, which exposes a design that forwards the level without a register or that lags by two cycles. It pushes at level 8 and pops at level 0, where a wrong guard would corrupt the external queue. It writes words wider than the frame at several frame sizes, so a truncation off by one bit shows in the pushed data. It also checks that an error flag does not persist past its single response cycle.

// File: rtl/ssp_regs_pkg.sv
package ssp_regs_pkg;

    localparam int BUS_AW    = 12;
    localparam int BUS_DW    = 32;
    localparam int FRAME_MAX = 16;
    localparam int CTRL0_W   = 16;
    localparam int CTRL1_W   = 4;
    localparam int PRESC_W   = 8;
    localparam int IRQ_W     = 4;

    // Word indexes (byte offset / 4) of the mapped registers
    localparam logic [9:0] W_CTRL0  = 10'h000;
    localparam logic [9:0] W_CTRL1  = 10'h001;
    localparam logic [9:0] W_DATA   = 10'h002;
    localparam logic [9:0] W_STAT   = 10'h003;
    localparam logic [9:0] W_PRESC  = 10'h004;
    localparam logic [9:0] W_MASK   = 10'h005;
    localparam logic [9:0] W_RAW    = 10'h006;
    localparam logic [9:0] W_MASKED = 10'h007;
    localparam logic [9:0] W_DMA    = 10'h008;
    // Address bits 11:5 of the identification window
    localparam logic [6:0] ID_BLOCK = 7'h7F;

    typedef enum logic [3:0] {
        SEL_CTRL0, SEL_CTRL1, SEL_DATA, SEL_STAT, SEL_PRESC,
        SEL_MASK, SEL_RAW, SEL_MASKED, SEL_DMA, SEL_ID, SEL_NONE
    } reg_sel_e;

    // Status word, bit 4 down to bit 0
    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;

    // Raw interrupt vector, bit 3 down to bit 0
    typedef struct packed {
        logic       tx_low;
        logic       rx_high;
        logic [1:0] spare;
    } irq_vec_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h22;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

    function automatic logic [FRAME_MAX-1:0] frame_mask(input logic [3:0] code);
        logic [FRAME_MAX:0] one_hot;
        one_hot    = {{FRAME_MAX{1'b0}}, 1'b1} << ({1'b0, code} + 5'd1);
        frame_mask = FRAME_MAX'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/ssp_addr_decode.sv
module ssp_addr_decode
    import ssp_regs_pkg::*;
(
    input  logic [BUS_AW-1:0] addr,
    output reg_sel_e          sel,
    output logic [2:0]        id_idx
);

    always_comb begin
        sel    = SEL_NONE;
        id_idx = addr[4:2];
        if (addr[1:0] == 2'b00) begin
            if (addr[11:5] == ID_BLOCK) begin
                sel = SEL_ID;
            end else begin
                case (addr[11:2])
                    W_CTRL0:  sel = SEL_CTRL0;
                    W_CTRL1:  sel = SEL_CTRL1;
                    W_DATA:   sel = SEL_DATA;
                    W_STAT:   sel = SEL_STAT;
                    W_PRESC:  sel = SEL_PRESC;
                    W_MASK:   sel = SEL_MASK;
                    W_RAW:    sel = SEL_RAW;
                    W_MASKED: sel = SEL_MASKED;
                    W_DMA:    sel = SEL_DMA;
                    default:  sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/ssp_cfg_regs.sv
module ssp_cfg_regs
    import ssp_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_sel_e           sel,
    input  logic [CTRL0_W-1:0] wdata,
    output logic [CTRL0_W-1:0] ctrl0_q,
    output logic [CTRL1_W-1:0] ctrl1_q,
    output logic [PRESC_W-1:0] presc_q,
    output logic [IRQ_W-1:0]   mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
            presc_q <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL0: ctrl0_q <= wdata;
                SEL_CTRL1: ctrl1_q <= wdata[CTRL1_W-1:0];
                SEL_PRESC: presc_q <= wdata[PRESC_W-1:0];
                SEL_MASK:  mask_q  <= wdata[IRQ_W-1:0];
                default: ;
            endcase
        end
    end

    // R13: the mask only moves on a write aimed at it
    a_r13_mask_holds: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_MASK) |=> $stable(mask_q));

    // R9: the prescaler only moves on a write aimed at it
    a_r9_presc_holds: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_PRESC) |=> $stable(presc_q));

endmodule

// File: rtl/ssp_flag_gen.sv
module ssp_flag_gen
    import ssp_regs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output stat_t            stat_q,
    output irq_vec_t         raw_q
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

    stat_t    stat_d;
    irq_vec_t raw_d;
    logic     seen_q;

    always_comb begin
        stat_d.tx_empty  = (tx_level == '0);
        stat_d.tx_nfull  = (tx_level < FULL_LVL);
        stat_d.rx_nempty = (rx_level != '0);
        stat_d.rx_full   = (rx_level >= FULL_LVL);
        stat_d.busy      = (tx_level != '0);
        raw_d.rx_high    = (rx_level >= HALF_LVL);
        raw_d.tx_low     = (tx_level <= HALF_LVL);
        raw_d.spare      = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '{busy: 1'b0, rx_full: 1'b0, rx_nempty: 1'b0,
                        tx_nfull: 1'b1, tx_empty: 1'b1};
            raw_q  <= '{tx_low: 1'b1, rx_high: 1'b0, spare: 2'b00};
            seen_q <= 1'b0;
        end else begin
            stat_q <= stat_d;
            raw_q  <= raw_d;
            seen_q <= 1'b1;
        end
    end

    // R2: empty and full flags follow the levels one cycle later
    a_r2_tx_empty: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> stat_q.tx_empty == ($past(tx_level) == '0));
    a_r2_rx_full: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> stat_q.rx_full == ($past(rx_level) >= FULL_LVL));

    // R3: busy is always the complement of transmit-empty
    a_r3_busy_vs_empty: assert property (@(posedge clk) disable iff (rst)
        stat_q.busy != stat_q.tx_empty);

    // R4: receive threshold and unused vector bits
    a_r4_rx_high: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> raw_q.rx_high == ($past(rx_level) >= HALF_LVL));
    a_r4_spare_zero: assert property (@(posedge clk) disable iff (rst)
        raw_q.spare == 2'b00);

endmodule

// File: rtl/ssp_reg_unit.sv
module ssp_reg_unit
    import ssp_regs_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [BUS_AW-1:0]    req_addr,
    input  logic [BUS_DW-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [BUS_DW-1:0]    rsp_rdata,
    output logic                 rsp_err,
    output logic                 tx_push,
    output logic [FRAME_MAX-1:0] tx_push_data,
    input  logic [LVL_W-1:0]     tx_level,
    output logic                 rx_pop,
    input  logic [FRAME_MAX-1:0] rx_pop_data,
    input  logic [LVL_W-1:0]     rx_level,
    output logic [CTRL0_W-1:0]   ctrl0_o,
    output logic [CTRL1_W-1:0]   ctrl1_o,
    output logic [PRESC_W-1:0]   presc_o,
    output logic                 irq
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    reg_sel_e          sel;
    logic [2:0]        id_idx;
    logic              acc_wr, acc_rd;
    logic [IRQ_W-1:0]  mask_q;
    stat_t             stat_q;
    irq_vec_t          raw_q;
    logic [IRQ_W-1:0]  raw_bits;
    logic [BUS_DW-1:0] rd_d;
    logic              seen_q;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^req_wdata[BUS_DW-1:CTRL0_W];
    assign req_ready       = 1'b1;
    assign acc_wr          = req_valid &  req_write;
    assign acc_rd          = req_valid & ~req_write;
    assign raw_bits        = raw_q;

    ssp_addr_decode u_dec (
        .addr   (req_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    ssp_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc_wr),
        .sel     (sel),
        .wdata   (req_wdata[CTRL0_W-1:0]),
        .ctrl0_q (ctrl0_o),
        .ctrl1_q (ctrl1_o),
        .presc_q (presc_o),
        .mask_q  (mask_q)
    );

    ssp_flag_gen #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .stat_q   (stat_q),
        .raw_q    (raw_q)
    );

    // Queue strobes act in the request cycle
    assign tx_push      = acc_wr && (sel == SEL_DATA) && (tx_level < FULL_LVL);
    assign tx_push_data = req_wdata[FRAME_MAX-1:0] & frame_mask(ctrl0_o[3:0]);
    assign rx_pop       = acc_rd && (sel == SEL_DATA) && (rx_level != '0);

    assign irq = |(raw_bits & mask_q);

    always_comb begin
        case (sel)
            SEL_CTRL0:  rd_d = {{(BUS_DW-CTRL0_W){1'b0}}, ctrl0_o};
            SEL_CTRL1:  rd_d = {{(BUS_DW-CTRL1_W){1'b0}}, ctrl1_o};
            SEL_DATA:   rd_d = (rx_level != '0) ?
                               {{(BUS_DW-FRAME_MAX){1'b0}}, rx_pop_data} : '0;
            SEL_STAT:   rd_d = {{(BUS_DW-5){1'b0}}, stat_q};
            SEL_PRESC:  rd_d = {{(BUS_DW-PRESC_W){1'b0}}, presc_o};
            SEL_MASK:   rd_d = {{(BUS_DW-IRQ_W){1'b0}}, mask_q};
            SEL_RAW:    rd_d = {{(BUS_DW-IRQ_W){1'b0}}, raw_bits};
            SEL_MASKED: rd_d = {{(BUS_DW-IRQ_W){1'b0}}, raw_bits & mask_q};
            SEL_ID:     rd_d = {{(BUS_DW-8){1'b0}}, id_byte(id_idx)};
            default:    rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            seen_q    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= acc_rd ? rd_d : '0;
            rsp_err   <= req_valid && (sel == SEL_NONE);
            seen_q    <= 1'b1;
        end
    end

    // R6: never pop an empty receive queue
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> rx_level != '0);

    // R7: never push a full transmit queue
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> tx_level < FULL_LVL);

    // R8: pushed word carries no bits above the frame
    a_r8_push_in_frame: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> (tx_push_data & ~frame_mask(ctrl0_o[3:0])) == '0);

    // R5: the line can only be high with some enable set
    a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> mask_q != '0);

    // R12: one response per request, one cycle later
    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> rsp_valid == $past(req_valid));

    // R11: an error only rides on a response
    a_r11_err_with_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);

endmodule

// File: tb/ssp_reg_unit_bench.sv
module ssp_reg_unit_bench;
    import ssp_regs_pkg::*;

    localparam int LW = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        tx_push, rx_pop;
    logic [15:0] tx_push_data, rx_pop_data;
    logic [LW-1:0] tx_level, rx_level;
    logic [15:0] ctrl0_o;
    logic [3:0]  ctrl1_o;
    logic [7:0]  presc_o;
    logic        irq;

    logic        s_push, s_pop, s_rvalid, s_err;
    logic [15:0] s_pdata;
    logic [31:0] s_rdata;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    ssp_reg_unit u_ssp_reg_unit (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_level(tx_level),
        .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .rx_level(rx_level),
        .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o), .presc_o(presc_o), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [3:0]  txl;
        logic [3:0]  rxl;
        logic [31:0] exp;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h00C, 32'h0,     4'd0, 4'd0, 32'h03, 1'b0, 8'd2},  // R2 both empty
        '{1'b0, 12'h00C, 32'h0,     4'd3, 4'd0, 32'h12, 1'b0, 8'd3},  // R3 busy
        '{1'b0, 12'h00C, 32'h0,     4'd8, 4'd8, 32'h1C, 1'b0, 8'd2},  // R2 full
        '{1'b0, 12'h00C, 32'h0,     4'd0, 4'd5, 32'h07, 1'b0, 8'd2},  // R2
        '{1'b0, 12'h018, 32'h0,     4'd4, 4'd4, 32'h0C, 1'b0, 8'd4},  // R4 edge
        '{1'b0, 12'h018, 32'h0,     4'd5, 4'd3, 32'h00, 1'b0, 8'd4},  // R4 edge
        '{1'b1, 12'h014, 32'h4,     4'd5, 4'd3, 32'h00, 1'b0, 8'd13}, // R13
        '{1'b0, 12'h014, 32'h0,     4'd5, 4'd3, 32'h04, 1'b0, 8'd13}, // R13
        '{1'b0, 12'h01C, 32'h0,     4'd5, 4'd4, 32'h04, 1'b0, 8'd5},  // R5
        '{1'b0, 12'h01C, 32'h0,     4'd4, 4'd3, 32'h00, 1'b0, 8'd5},  // R5
        '{1'b1, 12'h010, 32'h1234,  4'd0, 4'd0, 32'h00, 1'b0, 8'd9},  // R9
        '{1'b0, 12'h010, 32'h0,     4'd0, 4'd0, 32'h34, 1'b0, 8'd9},  // R9
        '{1'b1, 12'h000, 32'hFABC7, 4'd0, 4'd0, 32'h00, 1'b0, 8'd13}, // R13
        '{1'b0, 12'h000, 32'h0,     4'd0, 4'd0, 32'hABC7, 1'b0, 8'd13}, // R13
        '{1'b1, 12'h004, 32'hFF,    4'd0, 4'd0, 32'h00, 1'b0, 8'd13}, // R13
        '{1'b0, 12'h004, 32'h0,     4'd0, 4'd0, 32'h0F, 1'b0, 8'd13}, // R13
        '{1'b0, 12'hFE0, 32'h0,     4'd0, 4'd0, 32'h22, 1'b0, 8'd10}, // R10
        '{1'b0, 12'hFF0, 32'h0,     4'd0, 4'd0, 32'h0D, 1'b0, 8'd10}, // R10
        '{1'b0, 12'hFFC, 32'h0,     4'd0, 4'd0, 32'hB1, 1'b0, 8'd10}, // R10
        '{1'b0, 12'h020, 32'h0,     4'd0, 4'd0, 32'h00, 1'b0, 8'd11}, // R11 dma
        '{1'b0, 12'h024, 32'h0,     4'd0, 4'd0, 32'h00, 1'b1, 8'd11}, // R11 hole
        '{1'b0, 12'hFDC, 32'h0,     4'd0, 4'd0, 32'h00, 1'b1, 8'd11}  // R11 hole
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge that shows the response
    task automatic bus_op(input logic wr, input logic [11:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        s_push = tx_push; s_pdata = tx_push_data; s_pop = rx_pop;
        @(negedge clk);
        s_rvalid = rsp_valid; s_rdata = rsp_rdata; s_err = rsp_err;
        req_valid = 1'b0; req_write = 1'b0;
        chk("R12 response valid", {31'b0, s_rvalid}, 32'd1);
    endtask

    task automatic set_levels(input logic [LW-1:0] t, input logic [LW-1:0] r);
        tx_level = t; rx_level = r;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; tx_level = '0; rx_level = '0; rx_pop_data = 16'hBEEF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq low", {31'b0, irq}, 32'd0);
        chk("R1 no response", {31'b0, rsp_valid}, 32'd0);
        bus_op(1'b0, 12'h00C, 0); chk("R1 status", s_rdata, 32'h03);
        bus_op(1'b0, 12'h018, 0); chk("R1 raw", s_rdata, 32'h08);
        bus_op(1'b0, 12'h014, 0); chk("R1 mask", s_rdata, 32'h00);

        for (int i = 0; i < NV; i++) begin
            set_levels(VECS[i].txl, VECS[i].rxl);
            bus_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            chk($sformatf("R%0d vec %0d data", VECS[i].req, i), s_rdata, VECS[i].exp);
            chk($sformatf("R%0d vec %0d err", VECS[i].req, i), {31'b0, s_err}, {31'b0, VECS[i].err});
        end
        // R11 error lasts one cycle
        @(negedge clk);
        chk("R11 err pulse ends", {31'b0, rsp_err}, 32'd0);
        set_levels(0, 0);
        bus_op(1'b0, 12'h006, 0);
        chk("R11 misaligned err", {31'b0, s_err}, 32'd1);
        chk("R11 misaligned data", s_rdata, 32'd0);
        bus_op(1'b1, 12'h020, 32'hFFFF);
        chk("R11 dma write no err", {31'b0, s_err}, 32'd0);

        // R2 one-cycle lag: level changes in the request cycle
        tx_level = 4'd8;
        bus_op(1'b0, 12'h00C, 0); chk("R2 old status", s_rdata, 32'h03);
        bus_op(1'b0, 12'h00C, 0); chk("R2 new status", s_rdata, 32'h10);

        // R5 interrupt line
        set_levels(0, 0);
        bus_op(1'b1, 12'h014, 32'h8);
        set_levels(2, 0);
        chk("R5 irq tx low", {31'b0, irq}, 32'd1);
        set_levels(6, 0);
        chk("R5 irq off", {31'b0, irq}, 32'd0);
        set_levels(2, 0);
        chk("R5 irq again", {31'b0, irq}, 32'd1);
        bus_op(1'b1, 12'h014, 32'h0);
        chk("R5 irq masked", {31'b0, irq}, 32'd0);
        bus_op(1'b0, 12'h01C, 0); chk("R5 masked reads 0", s_rdata, 32'd0);

        // R6 data reads
        set_levels(0, 0);
        bus_op(1'b0, 12'h008, 0);
        chk("R6 empty no pop", {31'b0, s_pop}, 32'd0);
        chk("R6 empty reads 0", s_rdata, 32'd0);
        set_levels(0, 3);
        bus_op(1'b0, 12'h008, 0);
        chk("R6 pop", {31'b0, s_pop}, 32'd1);
        chk("R6 head word", s_rdata, 32'hBEEF);

        // R7 and R8 data writes; control 0 holds 0xABC7 (8-bit frame)
        set_levels(2, 0);
        bus_op(1'b1, 12'h008, 32'h1FF);
        chk("R7 push", {31'b0, s_push}, 32'd1);
        chk("R8 8-bit frame", {16'b0, s_pdata}, 32'h00FF);
        set_levels(8, 0);
        bus_op(1'b1, 12'h008, 32'h55);
        chk("R7 full drops", {31'b0, s_push}, 32'd0);
        set_levels(7, 0);
        bus_op(1'b1, 12'h008, 32'h55);
        chk("R7 level 7 pushes", {31'b0, s_push}, 32'd1);
        bus_op(1'b1, 12'h000, 32'hF);
        bus_op(1'b1, 12'h008, 32'h12345);
        chk("R8 16-bit frame", {16'b0, s_pdata}, 32'h2345);
        bus_op(1'b1, 12'h000, 32'h3);
        bus_op(1'b1, 12'h008, 32'hAB);
        chk("R8 4-bit frame", {16'b0, s_pdata}, 32'h000B);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule